// File: doc/BRIEF.md
# Divided or Pin-Sourced Port Clock Generator

This block produces the clock that times a group of I/O ports. It has two sources. In the internal source mode it divides a fast reference clock by twice a programmed value. In the external source mode it follows a one-bit input pin. The pin is synchronised first, and every change of its value becomes one clock edge. Whatever the source, the result comes out as a level and as two one-cycle strobes, one for rising edges and one for falling edges. All three are registered in the reference clock domain, so downstream port logic uses them as clock enables and not as real clocks.

Nothing moves until a start pulse arrives. This lets the ports be set up while the clock is quiet. A stop pulse halts the block at any time. It forces the level low and clears the divide counter, so the next start always opens with a full half period followed by a rising edge. The generated level can also be sent to an output pin, together with an output enable, so that an external device can sample data against it.

Top module: `edge_clock_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, level_o, rise_o, fall_o and pin_o are all 0.
- R2: Without a start pulse the outputs stay low and produce no strobe. When run_start_i and run_stop_i are high in the same cycle, the stop wins and the block stays idle.
- R3: In internal mode with div_val_i = N ≥ 1, start is sampled at reference edge k. The first rising edge then shows on the outputs after edge k+N. After that the level toggles every N cycles, which gives a period of 2N cycles.
- R4: In internal mode a divider value of 0 behaves exactly like 1: the level toggles on every reference cycle.
- R5: rise_o is high for exactly the first cycle in which level_o is 1. fall_o is high for exactly the first cycle in which level_o is 0 after being 1. The two strobes are never high together.
- R6: A stop pulse drives level_o to 0 in the next cycle. It pulses fall_o if the level was high, and it clears the divide counter, so a following start again waits N cycles for its first rise.
- R7: In external mode (src_ext_i = 1) ext_pin_i passes through a two-flop synchroniser. Each change of the synchronised value toggles the level, and the rise or fall strobe is chosen by the new level. A pin change set up before reference edge e reaches the outputs after edge e+2.
- R8: Pin changes that occur while the block is stopped are not stored. After a later start, the level does not move until the pin changes again.
- R9: pin_oe_o equals pin_drive_en_i. pin_o equals level_o while the drive is enabled and is 0 otherwise.
- R10: If div_val_i is lowered below the count already reached in the current half period, the level toggles on the very next reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_start_i | input | 1 | One-cycle start pulse |
| run_stop_i | input | 1 | One-cycle stop pulse (wins over start) |
| src_ext_i | input | 1 | 1 selects the external pin as the source, 0 selects the divider |
| div_val_i | input | DIV_W | Half-period in reference cycles (0 treated as 1) |
| ext_pin_i | input | 1 | Asynchronous external clock pin |
| pin_drive_en_i | input | 1 | Send the generated level to pin_o |
| rise_o | output | 1 | Rising-edge strobe |
| fall_o | output | 1 | Falling-edge strobe |
| level_o | output | 1 | Generated clock level |
| pin_o | output | 1 | Pin copy of the level |
| pin_oe_o | output | 1 | Output enable for pin_o |

## Verification
A wrong divide count appears at the ports as a first rise or a half period that is off by a cycle or more. It can be seen within 2N cycles of a start, so every divider setting gets its start latency and both half periods measured. A lost clear on stop only shows up on the next start, as a short first half period, so each setting is measured again after a stop. A synchroniser with the wrong depth or a broken change detector moves the pin-to-strobe latency away from three edges, or it makes pin changes from the stopped time appear later. Both effects are visible in the first cycles after the pin moves.

// File: rtl/edge_clk_pkg.sv
package edge_clk_pkg;

    // Registered state of the generator top
    typedef struct packed {
        logic running;
        logic level;
        logic rise;
        logic fall;
    } gen_state_t;

endpackage

// File: rtl/edge_pin_sync.sv
// Multi-flop synchroniser for the external clock pin with change detection.
module edge_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic change_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], pin_i};
        end else begin : g_single
            always_comb chain_d = pin_i;
        end
    endgenerate

    always_comb prev_d = chain_q[LAST];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign change_o = chain_q[LAST] ^ prev_q;

    // A detected change means the last stage moved on the previous edge
    assert_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        change_o |-> (chain_q[LAST] != $past(chain_q[LAST])));

endmodule

// File: rtl/edge_div_count.sv
// Half-period counter of the internal source; tick_o marks a toggle cycle.
module edge_div_count #(
    parameter int DIV_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] term;

    always_comb begin
        term   = (div_i == '0) ? '0 : div_i - DIV_W'(1);
        tick_o = run_i && (cnt_q >= term);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // Counter is cleared whenever the divider is not enabled
    assert_idle_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/edge_clock_gen.sv
// Port clock generator: divided reference or synchronised external pin.
module edge_clock_gen
    import edge_clk_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_start_i,
    input  logic             run_stop_i,
    input  logic             src_ext_i,
    input  logic [DIV_W-1:0] div_val_i,
    input  logic             ext_pin_i,
    input  logic             pin_drive_en_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic             level_o,
    output logic             pin_o,
    output logic             pin_oe_o
);
    gen_state_t st_d, st_q;
    logic       div_tick;
    logic       pin_change;
    logic       toggle;

    edge_div_count #(.DIV_W(DIV_W)) i_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (st_q.running && !src_ext_i),
        .div_i  (div_val_i),
        .tick_o (div_tick)
    );

    edge_pin_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .pin_i    (ext_pin_i),
        .change_o (pin_change)
    );

    always_comb begin
        toggle = st_q.running && (src_ext_i ? pin_change : div_tick);
        st_d      = st_q;
        st_d.rise = 1'b0;
        st_d.fall = 1'b0;
        if (run_stop_i) begin
            st_d.running = 1'b0;
            st_d.level   = 1'b0;
            st_d.fall    = st_q.level;
        end else begin
            if (run_start_i) st_d.running = 1'b1;
            if (toggle) begin
                st_d.level = ~st_q.level;
                st_d.rise  = ~st_q.level;
                st_d.fall  = st_q.level;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o   = st_q.rise;
    assign fall_o   = st_q.fall;
    assign level_o  = st_q.level;
    assign pin_oe_o = pin_drive_en_i;
    assign pin_o    = pin_drive_en_i & st_q.level;

    assert_rise_first_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (level_o && !$past(level_o)));

    assert_fall_first_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> (!level_o && $past(level_o)));

    assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o}));

    assert_stop_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_stop_i |=> (!level_o && !rise_o));

    assert_no_run_no_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.running && !run_start_i) |=> (!level_o && !rise_o));

endmodule

// File: tb/test_edge_clock_gen.sv
module test_edge_clock_gen;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, stop = 1'b0, ext = 1'b0, pin = 1'b0, drv = 1'b1;
    logic [DW-1:0] div = '0;
    logic          rise, fall, level, pin_out, pin_oe;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    edge_clock_gen #(.DIV_W(DW), .SYNC_STAGES(2)) i_edge_clock_gen (
        .clk_i(clk), .rst_ni(rst_n), .run_start_i(start), .run_stop_i(stop),
        .src_ext_i(ext), .div_val_i(div), .ext_pin_i(pin), .pin_drive_en_i(drv),
        .rise_o(rise), .fall_o(fall), .level_o(level), .pin_o(pin_out), .pin_oe_o(pin_oe)
    );

    // divider setting and its expected half period
    localparam int NV = 6;
    localparam int DIV_TAB  [NV] = '{0, 1, 2, 3, 4, 8};
    localparam int HALF_TAB [NV] = '{1, 1, 2, 3, 4, 8};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
    endtask

    // cycles until the chosen strobe is seen (sampled at negedge)
    task automatic wait_strobe(input bit want_rise, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(want_rise ? rise : fall) && n < 64);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        int cnt;
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 level in reset", int'(level), 0);
        check("R1 pin in reset", int'(pin_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobes after reset", int'(rise | fall), 0);
        check("R1 level after reset", int'(level), 0);

        // R2: nothing moves without start
        div = DW'(1);
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            cnt += int'(rise | level);
        end
        check("R2 no edge before start", cnt, 0);

        // R3/R4/R6: table of divider settings
        for (int i = 0; i < NV; i++) begin
            div = DW'(DIV_TAB[i]);
            for (int pass = 0; pass < 2; pass++) begin
                pulse_start();
                wait_strobe(1'b1, n);
                check((DIV_TAB[i] == 0) ? "R4 first rise div0" : "R3 first rise", n, HALF_TAB[i]);
                check("R5 level high at rise", int'(level), 1);
                check("R9 pin follows level", int'(pin_out), 1);
                wait_strobe(1'b0, n);
                check((DIV_TAB[i] == 0) ? "R4 high half div0" : "R3 high half", n, HALF_TAB[i]);
                check("R5 no rise at fall", int'(rise), 0);
                wait_strobe(1'b1, n);
                check((DIV_TAB[i] == 0) ? "R4 low half div0" : "R3 low half", n, HALF_TAB[i]);
                // second pass repeats start after stop: counter must be clear (R6)
                pulse_stop();
                check("R6 level low after stop", int'(level), 0);
            end
        end

        // R6: stop while high pulses fall
        div = DW'(4);
        pulse_start();
        wait_strobe(1'b1, n);
        @(negedge clk) stop = 1'b1;
        @(negedge clk) stop = 1'b0;
        check("R6 fall on stop", int'(fall), 1);
        check("R6 level on stop", int'(level), 0);
        @(negedge clk);
        check("R5 fall one cycle", int'(fall), 0);

        // R2: start and stop together -> stop wins
        @(negedge clk) begin start = 1'b1; stop = 1'b1; end
        @(negedge clk) begin start = 1'b0; stop = 1'b0; end
        cnt = 0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            cnt += int'(rise | level);
        end
        check("R2 stop wins over start", cnt, 0);

        // R10: divider lowered mid half-period
        div = DW'(8);
        pulse_start();
        wait_strobe(1'b1, n);
        repeat (5) @(negedge clk);
        div = DW'(2);
        @(negedge clk);
        check("R10 immediate toggle", int'(fall), 1);
        pulse_stop();

        // R9: drive disabled
        drv = 1'b0;
        div = DW'(3);
        pulse_start();
        wait_strobe(1'b1, n);
        check("R9 pin gated", int'(pin_out), 0);
        check("R9 oe low", int'(pin_oe), 0);
        drv = 1'b1;
        #1;
        check("R9 oe high", int'(pin_oe), 1);
        pulse_stop();

        // R7: external source
        ext = 1'b1;
        pulse_start();
        repeat (4) @(negedge clk);
        pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 no edge before sync", int'(rise | level), 0);
        @(negedge clk);
        check("R7 rise after sync", int'(rise), 1);
        check("R7 level high", int'(level), 1);
        repeat (3) @(negedge clk);
        pin = 1'b0;
        wait_strobe(1'b0, n);
        check("R7 fall latency", n, 3);
        pin = 1'b1;
        wait_strobe(1'b1, n);
        check("R7 rise latency", n, 3);

        // R8: changes while stopped are ignored
        pulse_stop();
        pin = 1'b0;
        repeat (6) @(negedge clk);
        check("R8 stopped level", int'(level), 0);
        pulse_start();
        cnt = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            cnt += int'(rise | level);
        end
        check("R8 no stale edge", cnt, 0);
        pin = 1'b1;
        wait_strobe(1'b1, n);
        check("R8 edge on new change", n, 3);

        finish_run();
    end
endmodule